// File: doc/BRIEF.md
# Release-to-Test Rotation Scheduler

This block moves a single free test slot around a rectangular grid of logic tiles so that, one at a time, every tile is emptied and tested while the rest of the grid keeps running. Each step moves the function held in a neighbouring tile into the free slot. The tile it leaves is then tested, and that tile becomes the new free slot. Each step runs two handshakes in a fixed order: a relocate request that carries source and destination coordinates and is held until the reconfiguration engine returns a done pulse, then a test request for the released tile that is held until the test engine returns a done pulse with a pass or fail result.

The free slot walks along a linear index from 0 to ROWS×COLS−1. It turns round at each end, so the sweep goes back and forth. The index becomes a tile position through one of two traversal orders. Column-first order suits mapped circuits with carry chains between vertically adjacent tiles. Row-first order is the other choice. The order input is taken only when the free slot sits at an end of the sweep. The block counts, for every tile, the steps since that tile was last tested, and keeps the largest such gap seen. A failed test records where the fault is and stops the rotation until it is cleared.

States: IDLE (waiting for `run`), RELOC (relocate request out), TEST (test request out), HALT (fault held). Transitions: IDLE→RELOC when `run` is high; RELOC→TEST on `reconf_done`; TEST→IDLE on `test_done` with a pass; TEST→HALT on `test_done` with `test_fail`; HALT→IDLE on `fault_clear`.

Top module: `rts_sched`

## Requirements
- R1: After reset both requests are low, `fault_flag` is low, `worst_latency` is 0, the free slot is at index 0 and the sweep direction is ascending.
- R2: A step begins with `reloc_req` high. Its source is the tile at the next index and its destination is the tile at the current free index. The request stays high until the cycle in which `reconf_done` is seen.
- R3: The edge that samples `reconf_done` drops `reloc_req` and raises `test_req`. The test coordinates equal the relocation source, and the request stays high until `test_done`.
- R4: The next index is the current index plus one while ascending and minus one while descending. The direction turns to descending when the index reaches ROWS×COLS−1 and to ascending when it reaches 0.
- R5: With the row-first order (active order bit 0), index i maps to row i/COLS, column i%COLS. With column-first order (bit 1), it maps to row i%ROWS, column i/ROWS.
- R6: `vertical_sel` is copied into the active order only when a step begins with the free index at 0 or at ROWS×COLS−1. A change made at any other index has no effect on the coordinates until then.
- R7: Each completed step records, for the tested tile, the number of steps since its previous test (reset counts as a test of every tile). `worst_latency` holds the largest value recorded and never decreases. A full back-and-forth sweep of the grid takes it to 2×(ROWS×COLS−1).
- R8: `test_done` with `test_fail` completes the step, sets `fault_flag` and captures the tested tile in `fault_row`/`fault_col`. No request is issued until `fault_clear`, whatever `run` does.
- R9: With `run` low in IDLE no step begins. A step already under way runs to completion.
- R10: `reloc_req` and `test_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Allows new steps to begin |
| vertical_sel | input | 1 | Requested traversal order: 1 column-first, 0 row-first |
| reconf_done | input | 1 | Relocation finished (pulse) |
| test_done | input | 1 | Test finished (pulse) |
| test_fail | input | 1 | Result that comes with `test_done`: 1 means the tile is faulty |
| fault_clear | input | 1 | Releases a halt caused by a fault |
| reloc_req | output | 1 | Relocate request |
| reloc_src_row | output | RW | Row of the tile whose function moves |
| reloc_src_col | output | CW | Column of the tile whose function moves |
| reloc_dst_row | output | RW | Row of the free tile that receives it |
| reloc_dst_col | output | CW | Column of the free tile that receives it |
| test_req | output | 1 | Test request |
| test_row | output | RW | Row of the tile under test |
| test_col | output | CW | Column of the tile under test |
| fault_flag | output | 1 | A fault is held and rotation is halted |
| fault_row | output | RW | Row of the faulty tile |
| fault_col | output | CW | Column of the faulty tile |
| order_vertical | output | 1 | Traversal order currently in force |
| worst_latency | output | LAT_W | Largest retest gap seen, in steps |

## Verification
`reloc_req` rises on the clock edge after `run` is seen in IDLE. `test_req` replaces it on the edge that samples `reconf_done`. The free index, the latency figures and the fault capture all change on the edge that samples `test_done`. The bench drives every input at the falling edge and reads results at the next falling edge after the edge that causes them, so each result is read one half-period after it is due. A reference model in the bench moves forward only at those sampled handshakes. It holds the index, the direction, the order latch and the per-tile gaps, and from them it predicts every coordinate and the value of `worst_latency`.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RELOC = 2'd1,
        ST_TEST  = 2'd2,
        ST_HALT  = 2'd3
    } rts_state_e;

endpackage

// File: rtl/rts_walker.sv
// Free-slot position along the linear sweep, its direction, and the
// traversal order latched at the sweep ends.
module rts_walker #(
    parameter int NTILES = 12,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_start,
    input  logic             step_commit,
    input  logic             vert_in,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             vert_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NTILES - 1);

    logic ascending;

    always_comb begin
        if (ascending) nxt_idx = cur_idx + IDX_W'(1);
        else           nxt_idx = cur_idx - IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            ascending <= 1'b1;
            vert_q    <= 1'b0;
        end else begin
            if (step_start && ((cur_idx == '0) || (cur_idx == LAST)))
                vert_q <= vert_in;
            if (step_commit) begin
                cur_idx <= nxt_idx;
                if (nxt_idx == LAST)    ascending <= 1'b0;
                else if (nxt_idx == '0) ascending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rts_coord_map.sv
// Linear sweep index to (row, column) for the selected traversal order.
module rts_coord_map #(
    parameter int ROWS  = 3,
    parameter int COLS  = 4,
    parameter int IDX_W = 4,
    parameter int RW    = 2,
    parameter int CW    = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             vert,
    output logic [RW-1:0]    row,
    output logic [CW-1:0]    col
);
    int unsigned iv;

    always_comb begin
        iv = 32'(idx);
        if (vert) begin
            row = RW'(iv % ROWS);
            col = CW'(iv / ROWS);
        end else begin
            row = RW'(iv / COLS);
            col = CW'(iv % COLS);
        end
    end
endmodule

// File: rtl/rts_latency.sv
// Per-tile retest gap counters, counted in steps, and the worst gap seen.
module rts_latency #(
    parameter int NTILES = 12,
    parameter int TID_W  = 4,
    parameter int LAT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_commit,
    input  logic [TID_W-1:0] tested_id,
    output logic [LAT_W-1:0] worst
);
    localparam logic [LAT_W-1:0] SAT = {LAT_W{1'b1}};

    logic [LAT_W-1:0] gap [NTILES];
    logic [LAT_W-1:0] seen;

    always_comb begin
        if (gap[tested_id] == SAT) seen = SAT;
        else                       seen = gap[tested_id] + LAT_W'(1);
    end

    for (genvar t = 0; t < NTILES; t++) begin : g_tile
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gap[t] <= '0;
            end else if (step_commit) begin
                if (tested_id == TID_W'(t)) gap[t] <= '0;
                else if (gap[t] != SAT)     gap[t] <= gap[t] + LAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           worst <= '0;
        else if (step_commit && seen > worst) worst <= seen;
    end
endmodule

// File: rtl/rts_sched.sv
module rts_sched #(
    parameter int ROWS   = 3,
    parameter int COLS   = 4,
    parameter int NTILES = ROWS * COLS,
    parameter int IDX_W  = (NTILES > 1) ? $clog2(NTILES) : 1,
    parameter int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int CW     = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int LAT_W  = $clog2(2 * NTILES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             vertical_sel,
    input  logic             reconf_done,
    input  logic             test_done,
    input  logic             test_fail,
    input  logic             fault_clear,
    output logic             reloc_req,
    output logic [RW-1:0]    reloc_src_row,
    output logic [CW-1:0]    reloc_src_col,
    output logic [RW-1:0]    reloc_dst_row,
    output logic [CW-1:0]    reloc_dst_col,
    output logic             test_req,
    output logic [RW-1:0]    test_row,
    output logic [CW-1:0]    test_col,
    output logic             fault_flag,
    output logic [RW-1:0]    fault_row,
    output logic [CW-1:0]    fault_col,
    output logic             order_vertical,
    output logic [LAT_W-1:0] worst_latency
);
    import rts_pkg::*;

    rts_state_e state_q, state_d;

    logic             step_start, step_commit;
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic [RW-1:0]    cur_row, nxt_row;
    logic [CW-1:0]    cur_col, nxt_col;
    logic [IDX_W-1:0] tested_id;
    logic             fault_q;
    logic [RW-1:0]    frow_q;
    logic [CW-1:0]    fcol_q;

    assign step_start  = (state_q == ST_IDLE) && run;
    assign step_commit = (state_q == ST_TEST) && test_done;

    rts_walker #(.NTILES(NTILES), .IDX_W(IDX_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_start (step_start),
        .step_commit(step_commit),
        .vert_in    (vertical_sel),
        .cur_idx    (cur_idx),
        .nxt_idx    (nxt_idx),
        .vert_q     (order_vertical)
    );

    rts_coord_map #(.ROWS(ROWS), .COLS(COLS), .IDX_W(IDX_W), .RW(RW), .CW(CW)) u_map_cur (
        .idx (cur_idx),
        .vert(order_vertical),
        .row (cur_row),
        .col (cur_col)
    );

    rts_coord_map #(.ROWS(ROWS), .COLS(COLS), .IDX_W(IDX_W), .RW(RW), .CW(CW)) u_map_nxt (
        .idx (nxt_idx),
        .vert(order_vertical),
        .row (nxt_row),
        .col (nxt_col)
    );

    // Physical tile number, independent of the traversal order in force.
    assign tested_id = IDX_W'(32'(nxt_row) * COLS + 32'(nxt_col));

    rts_latency #(.NTILES(NTILES), .TID_W(IDX_W), .LAT_W(LAT_W)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_commit(step_commit),
        .tested_id  (tested_id),
        .worst      (worst_latency)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run)         state_d = ST_RELOC;
            ST_RELOC: if (reconf_done) state_d = ST_TEST;
            ST_TEST:  if (test_done)   state_d = test_fail ? ST_HALT : ST_IDLE;
            ST_HALT:  if (fault_clear) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        reloc_req     = 1'b0;
        test_req      = 1'b0;
        reloc_src_row = nxt_row;
        reloc_src_col = nxt_col;
        reloc_dst_row = cur_row;
        reloc_dst_col = cur_col;
        test_row      = nxt_row;
        test_col      = nxt_col;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RELOC: reloc_req = 1'b1;
            ST_TEST:  test_req  = 1'b1;
            ST_HALT:  ;
        endcase
    end

    // Fault capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            frow_q  <= '0;
            fcol_q  <= '0;
        end else if (step_commit && test_fail) begin
            fault_q <= 1'b1;
            frow_q  <= nxt_row;
            fcol_q  <= nxt_col;
        end else if ((state_q == ST_HALT) && fault_clear) begin
            fault_q <= 1'b0;
        end
    end

    assign fault_flag = fault_q;
    assign fault_row  = frow_q;
    assign fault_col  = fcol_q;
endmodule

// File: rtl/rts_sched_chk.sv
module rts_sched_chk #(
    parameter int RW    = 2,
    parameter int CW    = 2,
    parameter int LAT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reconf_done,
    input logic             test_done,
    input logic             fault_clear,
    input logic             reloc_req,
    input logic [RW-1:0]    reloc_src_row,
    input logic [CW-1:0]    reloc_src_col,
    input logic             test_req,
    input logic [RW-1:0]    test_row,
    input logic [CW-1:0]    test_col,
    input logic             fault_flag,
    input logic [RW-1:0]    fault_row,
    input logic [CW-1:0]    fault_col,
    input logic [LAT_W-1:0] worst_latency
);
    // R10
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reloc_req && test_req));

    // R2
    reloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reloc_req && !reconf_done) |=> reloc_req);

    // R3
    reloc_to_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reloc_req && reconf_done) |=> (test_req && !reloc_req));

    // R3
    test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !test_done) |=> test_req);

    // R3
    test_coord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_req) |-> (test_row == $past(reloc_src_row) && test_col == $past(reloc_src_col)));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clear) |=> (fault_flag && !reloc_req && !test_req));

    // R8
    fault_coord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clear) |=> ($stable(fault_row) && $stable(fault_col)));

    // R7
    worst_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (worst_latency >= $past(worst_latency)));
endmodule

bind rts_sched rts_sched_chk #(.RW(RW), .CW(CW), .LAT_W(LAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reconf_done  (reconf_done),
    .test_done    (test_done),
    .fault_clear  (fault_clear),
    .reloc_req    (reloc_req),
    .reloc_src_row(reloc_src_row),
    .reloc_src_col(reloc_src_col),
    .test_req     (test_req),
    .test_row     (test_row),
    .test_col     (test_col),
    .fault_flag   (fault_flag),
    .fault_row    (fault_row),
    .fault_col    (fault_col),
    .worst_latency(worst_latency)
);

// File: tb/sim_rts_sched.sv
`timescale 1ns/1ps
module sim_rts_sched;
    localparam int R  = 3;
    localparam int C  = 4;
    localparam int N  = R * C;
    localparam int RW = 2;
    localparam int CW = 2;
    localparam int LW = $clog2(2 * N) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, vertical_sel = 1'b0, reconf_done = 1'b0;
    logic test_done = 1'b0, test_fail = 1'b0, fault_clear = 1'b0;
    logic reloc_req, test_req, fault_flag, order_vertical;
    logic [RW-1:0] reloc_src_row, reloc_dst_row, test_row, fault_row;
    logic [CW-1:0] reloc_src_col, reloc_dst_col, test_col, fault_col;
    logic [LW-1:0] worst_latency;

    always #2 clk = ~clk;

    rts_sched #(.ROWS(R), .COLS(C)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .vertical_sel(vertical_sel),
        .reconf_done(reconf_done), .test_done(test_done), .test_fail(test_fail),
        .fault_clear(fault_clear), .reloc_req(reloc_req),
        .reloc_src_row(reloc_src_row), .reloc_src_col(reloc_src_col),
        .reloc_dst_row(reloc_dst_row), .reloc_dst_col(reloc_dst_col),
        .test_req(test_req), .test_row(test_row), .test_col(test_col),
        .fault_flag(fault_flag), .fault_row(fault_row), .fault_col(fault_col),
        .order_vertical(order_vertical), .worst_latency(worst_latency)
    );

    int n_run = 0, n_bad = 0;
    bit finished = 1'b0;

    // reference model
    int m_idx = 0;
    bit m_up = 1'b1;
    bit m_vert = 1'b0;
    int m_gap [N];
    int m_worst = 0;

    function automatic int map_r(int i, bit v);
        return v ? i % R : i / C;
    endfunction
    function automatic int map_c(int i, bit v);
        return v ? i / R : i % C;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_sig(input bit which_test, input string tag);
        int k = 0;
        while ((which_test ? test_req : reloc_req) !== 1'b1 && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk(k < 50, tag, k, 0);
    endtask

    // One full step; hold gives handshake delay, fail injects a fault.
    task automatic do_step(input int hold, input bit fail, input bit drop_run);
        int nx, tid;
        wait_sig(1'b0, "R2 reloc_req timeout");
        if (drop_run) run = 1'b0;
        if (m_idx == 0 || m_idx == N - 1) m_vert = vertical_sel;
        nx = m_up ? m_idx + 1 : m_idx - 1;
        chk(reloc_src_row == map_r(nx, m_vert) && reloc_src_col == map_c(nx, m_vert),
            "R2/R4/R5 src", int'(reloc_src_row) * 16 + int'(reloc_src_col),
            map_r(nx, m_vert) * 16 + map_c(nx, m_vert));
        chk(reloc_dst_row == map_r(m_idx, m_vert) && reloc_dst_col == map_c(m_idx, m_vert),
            "R2/R5 dst", int'(reloc_dst_row) * 16 + int'(reloc_dst_col),
            map_r(m_idx, m_vert) * 16 + map_c(m_idx, m_vert));
        chk(order_vertical == m_vert, "R6 order", order_vertical, m_vert);
        repeat (hold) @(negedge clk);
        chk(reloc_req === 1'b1 && test_req === 1'b0, "R2 hold", reloc_req, 1);
        reconf_done = 1'b1;
        @(negedge clk);
        reconf_done = 1'b0;
        chk(test_req === 1'b1 && reloc_req === 1'b0, "R3 test_req", test_req, 1);
        chk(test_row == map_r(nx, m_vert) && test_col == map_c(nx, m_vert), "R3 coords",
            int'(test_row) * 16 + int'(test_col), map_r(nx, m_vert) * 16 + map_c(nx, m_vert));
        repeat (hold) @(negedge clk);
        chk(test_req === 1'b1, "R3 hold", test_req, 1);
        test_done = 1'b1;
        test_fail = fail;
        @(negedge clk);
        test_done = 1'b0;
        test_fail = 1'b0;
        tid = map_r(nx, m_vert) * C + map_c(nx, m_vert);
        for (int t = 0; t < N; t++) begin
            if (t == tid) begin
                if (m_gap[t] + 1 > m_worst) m_worst = m_gap[t] + 1;
                m_gap[t] = 0;
            end else m_gap[t] = m_gap[t] + 1;
        end
        m_idx = nx;
        if (m_idx == N - 1) m_up = 1'b0;
        else if (m_idx == 0) m_up = 1'b1;
        chk(worst_latency == m_worst, "R7 worst", worst_latency, m_worst);
        if (fail) begin
            chk(fault_flag === 1'b1, "R8 flag", fault_flag, 1);
            chk(fault_row == map_r(nx, m_vert) && fault_col == map_c(nx, m_vert), "R8 coords",
                int'(fault_row) * 16 + int'(fault_col), map_r(nx, m_vert) * 16 + map_c(nx, m_vert));
        end
    endtask

    initial begin
        for (int t = 0; t < N; t++) m_gap[t] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(reloc_req === 1'b0 && test_req === 1'b0, "R1 requests", reloc_req, 0);
        chk(fault_flag === 1'b0, "R1 fault", fault_flag, 0);
        chk(worst_latency == 0, "R1 worst", worst_latency, 0);
        rst_n = 1'b1;
        // R9 idle without run
        repeat (5) begin
            @(negedge clk);
            chk(reloc_req === 1'b0, "R9 idle", reloc_req, 0);
        end
        run = 1'b1;
        // first step must go 0 -> 1 (R1)
        do_step(0, 1'b0, 1'b0);
        chk(m_idx == 1 && reloc_req === 1'b0, "R1 first step", m_idx, 1);
        // row-first sweeps over both ends (R4, R5)
        for (int s = 0; s < 16; s++) do_step(s % 3, 1'b0, 1'b0);
        // change order mid-sweep: must not act until an end (R6)
        vertical_sel = 1'b1;
        for (int s = 0; s < 30; s++) do_step(s % 2, 1'b0, 1'b0);
        chk(m_vert == 1'b1, "R6 latched", m_vert, 1);
        chk(worst_latency == 2 * (N - 1), "R7 full sweep", worst_latency, 2 * (N - 1));
        // fault halts rotation (R8)
        do_step(1, 1'b1, 1'b0);
        repeat (6) begin
            @(negedge clk);
            chk(reloc_req === 1'b0 && fault_flag === 1'b1, "R8 halted", reloc_req, 0);
        end
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        chk(fault_flag === 1'b0, "R8 clear", fault_flag, 0);
        vertical_sel = 1'b0;
        for (int s = 0; s < 12; s++) do_step(1, 1'b0, 1'b0);
        // run dropped mid-step: step completes, no new one (R9)
        do_step(2, 1'b0, 1'b1);
        repeat (5) begin
            @(negedge clk);
            chk(reloc_req === 1'b0 && test_req === 1'b0, "R9 stopped", reloc_req, 0);
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule